// File: doc/BRIEF.md
# Host-Writable Parallel Port Latch

This block holds the byte that an 8-line bidirectional port drives. Core logic can load the byte in two ways. One load combines a 4-bit accumulator nibble with a 4-bit data-memory nibble. The other load takes an 8-bit constant. A driver-enable bit, written by the core, decides whether the pins carry the byte or float as inputs. The pins themselves can always be read back into the core data path, whatever state the driver enable is in.

A mode pin selects host-bus operation when it is held low. In that mode, three general inputs are repurposed as active-low read strobe, chip select and write strobe. An external CPU can then write the latch: on the trailing edge of its write strobe, while chip select is active, the byte present on the pins is captured. Both strobes and the select are synchronised to the core clock before use. If a host capture and a core load fall in the same cycle, the host capture wins. In host-bus mode, one general-purpose pin is also driven as an output toward the host. The tri-state pins are modelled as a drive value plus an output enable.

Top module: `host_port_latch`

## Requirements
- R1: After reset the latch reads 0x00 on `port_drive`, `port_oe` is 0, and `gp0_oe` follows only the mode pin.
- R2: With `ld_const` high at a clock edge, the latch takes `const_byte` at that edge.
- R3: With `ld_split` high and `ld_const` low, the latch takes `acc_nib` in bits 7:4 and `mem_nib` in bits 3:0. When both are high, `ld_const` wins.
- R4: With `en_wr` high at an edge, the driver enable takes `en_val`. `port_oe` shows the driver enable, and `port_drive` always carries the latch value.
- R5: `rd_data` equals `pad_in` at all times, whether or not the drivers are enabled.
- R6: When `hostbus_n` is low, `gin[1]` is the read strobe, `gin[2]` the chip select and `gin[3]` the write strobe, all active low. A 0-to-1 change on `gin[3]` while `gin[2]` is low captures `pad_in` into the latch on the third clock edge after the change, with two synchroniser stages.
- R7: A write-strobe rise has no effect on the latch when chip select is high or when `hostbus_n` is high.
- R8: When a host capture and a core load (`ld_const` or `ld_split`) fall on the same edge, the latch takes the pin value.
- R9: `host_rd` is 1 once a low read strobe and a low chip select have passed the two synchroniser stages (after the second edge), and only while `hostbus_n` is low.
- R10: While `hostbus_n` is low, `gp0_oe` is 1 and `gp0_drive` equals `gp0_val`. Otherwise both are 0.
- R11: With no core load and no host capture, the latch holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_const | input | 1 | Load the latch from `const_byte` |
| const_byte | input | 8 | Constant byte for the core load |
| ld_split | input | 1 | Load the latch from the two nibbles |
| acc_nib | input | 4 | Accumulator nibble (upper half) |
| mem_nib | input | 4 | Data-memory nibble (lower half) |
| en_wr | input | 1 | Write strobe for the driver enable |
| en_val | input | 1 | New driver-enable value |
| hostbus_n | input | 1 | Low selects host-bus mode |
| gin | input | 3 | General inputs 3..1: write strobe, chip select, read strobe |
| pad_in | input | 8 | Current pin values of the port |
| gp0_val | input | 1 | Value for the general pin when in host-bus mode |
| port_drive | output | 8 | Value driven onto the port (the latch) |
| port_oe | output | 1 | Port driver enable |
| rd_data | output | 8 | Pin read-back to the core |
| host_rd | output | 1 | Synchronised host read request |
| gp0_drive | output | 1 | Drive value for the general pin |
| gp0_oe | output | 1 | Output enable for the general pin |

## Verification
The bench builds the block with its default 8-bit width and two synchroniser stages. At this size, every constant byte and all 256 nibble pairs can be swept exhaustively. Host writes run across a spread of pin patterns, covering the accepted case and each gated-off case. The two-stage setting fixes the capture at the third edge after the strobe rises, so the bench can aim a core load at exactly that edge to test which writer wins.

// File: rtl/host_port_latch.sv
module host_port_latch #(
  parameter int PW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_const,
  input  logic [PW-1:0] const_byte,
  input  logic          ld_split,
  input  logic [PW/2-1:0] acc_nib,
  input  logic [PW/2-1:0] mem_nib,
  input  logic          en_wr,
  input  logic          en_val,
  input  logic          hostbus_n,
  input  logic [3:1]    gin,
  input  logic [PW-1:0] pad_in,
  input  logic          gp0_val,
  output logic [PW-1:0] port_drive,
  output logic          port_oe,
  output logic [PW-1:0] rd_data,
  output logic          host_rd,
  output logic          gp0_drive,
  output logic          gp0_oe
);
  localparam int TOP = SYNC - 1;

  logic [PW-1:0]   q;
  logic            drv_en;
  logic [TOP:0]    rd_sh, cs_sh, wr_sh;
  logic            wr_prev;
  logic            host_mode, wr_rise, host_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sh   <= '1;
      cs_sh   <= '1;
      wr_sh   <= '1;
      wr_prev <= 1'b1;
    end else begin
      rd_sh   <= {rd_sh[TOP-1:0], gin[1]};
      cs_sh   <= {cs_sh[TOP-1:0], gin[2]};
      wr_sh   <= {wr_sh[TOP-1:0], gin[3]};
      wr_prev <= wr_sh[TOP];
    end
  end

  assign host_mode = !hostbus_n;
  assign wr_rise   = wr_sh[TOP] && !wr_prev;
  assign host_cap  = host_mode && wr_rise && !cs_sh[TOP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= '0;
    else if (host_cap)  q <= pad_in;
    else if (ld_const)  q <= const_byte;
    else if (ld_split)  q <= {acc_nib, mem_nib};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      drv_en <= 1'b0;
    else if (en_wr)  drv_en <= en_val;
  end

  assign port_drive = q;
  assign port_oe    = drv_en;
  assign rd_data    = pad_in;
  assign host_rd    = host_mode && !rd_sh[TOP] && !cs_sh[TOP];
  assign gp0_oe     = host_mode;
  assign gp0_drive  = host_mode && gp0_val;
endmodule

module host_port_latch_chk #(
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_const,
  input logic [PW-1:0] const_byte,
  input logic          ld_split,
  input logic [PW/2-1:0] acc_nib,
  input logic [PW/2-1:0] mem_nib,
  input logic          en_wr,
  input logic          en_val,
  input logic          hostbus_n,
  input logic [PW-1:0] pad_in,
  input logic          gp0_val,
  input logic [PW-1:0] port_drive,
  input logic          port_oe,
  input logic          gp0_drive,
  input logic          gp0_oe,
  input logic          host_cap
);
  // R2
  const_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_const && !host_cap) |=> port_drive == $past(const_byte));
  // R3
  split_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_split && !ld_const && !host_cap) |=> port_drive == {$past(acc_nib), $past(mem_nib)});
  // R4
  drv_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> port_oe == $past(en_val));
  // R6
  host_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_cap |=> port_drive == $past(pad_in));
  // R7
  host_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hostbus_n |-> !host_cap);
  // R10
  gp0_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gp0_oe == !hostbus_n && gp0_drive == (!hostbus_n && gp0_val));
  // R11
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_const && !ld_split && !host_cap) |=> $stable(port_drive));
endmodule

bind host_port_latch host_port_latch_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_const(ld_const), .const_byte(const_byte),
  .ld_split(ld_split), .acc_nib(acc_nib), .mem_nib(mem_nib),
  .en_wr(en_wr), .en_val(en_val), .hostbus_n(hostbus_n), .pad_in(pad_in),
  .gp0_val(gp0_val), .port_drive(port_drive), .port_oe(port_oe),
  .gp0_drive(gp0_drive), .gp0_oe(gp0_oe), .host_cap(host_cap)
);

// File: tb/sim_host_port_latch.sv
module sim_host_port_latch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_const = 0, ld_split = 0, en_wr = 0, en_val = 0;
  logic [7:0] const_byte = 0, pad_in = 0;
  logic [3:0] acc_nib = 0, mem_nib = 0;
  logic hostbus_n = 1, gp0_val = 0;
  logic [3:1] gin = 3'b111;
  logic [7:0] port_drive, rd_data;
  logic port_oe, host_rd, gp0_drive, gp0_oe;
  int runs = 0, fails = 0;

  always #2 clk = ~clk;

  host_port_latch u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  // pulses the write strobe low, then raises it; stops just after the second edge following the rise
  task automatic host_pulse(input logic [7:0] pv, input logic cs);
    pad_in = pv; gin[2] = cs; gin[3] = 1'b0;
    tick(3);
    gin[3] = 1'b1;
    tick(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #1;
    chk(port_drive == 8'h00 && port_oe == 1'b0, "R1 reset", {port_oe, port_drive}, 0);
    tick(2);
    rst_n = 1;
    tick();
    chk(port_drive == 8'h00 && port_oe == 1'b0, "R1 after release", {port_oe, port_drive}, 0);
    chk(gp0_oe == 1'b0, "R1 gp0", gp0_oe, 0);

    for (int v = 0; v < 256; v++) begin
      const_byte = v[7:0]; ld_const = 1; tick(); ld_const = 0;
      chk(port_drive == v[7:0], "R2 const load", port_drive, v);
    end

    for (int a = 0; a < 16; a++)
      for (int m = 0; m < 16; m++) begin
        acc_nib = a[3:0]; mem_nib = m[3:0]; ld_split = 1; tick(); ld_split = 0;
        chk(port_drive == (a * 16 + m), "R3 split load", port_drive, a * 16 + m);
      end
    acc_nib = 4'h1; mem_nib = 4'h2; const_byte = 8'hC7;
    ld_split = 1; ld_const = 1; tick(); ld_split = 0; ld_const = 0;
    chk(port_drive == 8'hC7, "R3 const priority", port_drive, 8'hC7);

    const_byte = 8'h3C; tick(5);
    chk(port_drive == 8'hC7, "R11 hold", port_drive, 8'hC7);

    en_val = 1; en_wr = 1; tick(); en_wr = 0;
    chk(port_oe == 1'b1, "R4 enable set", port_oe, 1);
    chk(port_drive == 8'hC7, "R4 drive carries latch", port_drive, 8'hC7);
    en_val = 0; tick();
    chk(port_oe == 1'b1, "R4 no write keeps", port_oe, 1);
    en_wr = 1; tick(); en_wr = 0;
    chk(port_oe == 1'b0, "R4 enable clear", port_oe, 0);

    for (int p = 0; p < 256; p += 17) begin
      pad_in = p[7:0]; #1;
      chk(rd_data == p[7:0], "R5 readback oe=0", rd_data, p);
    end
    en_val = 1; en_wr = 1; tick(); en_wr = 0;
    for (int p = 5; p < 256; p += 50) begin
      pad_in = p[7:0]; #1;
      chk(rd_data == p[7:0], "R5 readback oe=1", rd_data, p);
    end

    hostbus_n = 0; gp0_val = 1; #1;
    chk(gp0_oe == 1'b1 && gp0_drive == 1'b1, "R10 host gp0 hi", {gp0_oe, gp0_drive}, 3);
    gp0_val = 0; #1;
    chk(gp0_oe == 1'b1 && gp0_drive == 1'b0, "R10 host gp0 lo", {gp0_oe, gp0_drive}, 2);

    for (int k = 0; k < 16; k++) begin
      logic [7:0] pv;
      pv = 8'(k * 29 + 11);
      const_byte = 8'h00; ld_const = 1; tick(); ld_const = 0;
      host_pulse(pv, 1'b0);
      chk(port_drive == 8'h00, "R6 not before third edge", port_drive, 0);
      tick();
      chk(port_drive == pv, "R6 host capture", port_drive, pv);
    end

    host_pulse(8'h55, 1'b1); tick(2);
    chk(port_drive != 8'h55, "R7 cs high ignored", port_drive, 8'h00);
    const_byte = 8'hA0; ld_const = 1; tick(); ld_const = 0;
    hostbus_n = 1; host_pulse(8'h5A, 1'b0); tick(2);
    chk(port_drive == 8'hA0, "R7 mode off ignored", port_drive, 8'hA0);
    chk(gp0_oe == 1'b0 && gp0_drive == 1'b0, "R10 non-host gp0", {gp0_oe, gp0_drive}, 0);
    hostbus_n = 0;

    host_pulse(8'h96, 1'b0);
    const_byte = 8'h21; ld_const = 1; ld_split = 1; tick(); ld_const = 0; ld_split = 0;
    chk(port_drive == 8'h96, "R8 host beats core", port_drive, 8'h96);

    gin = 3'b111; tick(3);
    chk(host_rd == 1'b0, "R9 idle", host_rd, 0);
    gin[2] = 0; gin[1] = 0; tick();
    chk(host_rd == 1'b0, "R9 after one edge", host_rd, 0);
    tick();
    chk(host_rd == 1'b1, "R9 after two edges", host_rd, 1);
    hostbus_n = 1; #1;
    chk(host_rd == 1'b0, "R9 mode off", host_rd, 0);
    hostbus_n = 0; gin[2] = 1; tick(2);
    chk(host_rd == 1'b0, "R9 cs high", host_rd, 0);

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule